// File: doc/BRIEF.md
# Cascaded Interrupt Pending Controller

This block collects interrupt requests into two banks of pending bits, each with its own enable mask, and drives one interrupt line toward a processor. Software never rewrites a register whole. Each register has one address where ones in the write data set bits, and another address where ones clear bits. Two masters can therefore touch different bits without a read-modify-write race.

The second bank is cascaded into the first. The top bit of the first pending register shows whether any bit of the second pending register is set. The top bit of the first mask register is kept at one, so the second bank always reaches the interrupt line. Hardware sources set pending bits on their rising edges. Such an edge wins over a clear write that lands in the same clock cycle.

Top module: `casc_intc`

## Requirements
- R1: After reset both pending registers and mask register 1 read zero, mask register 0 reads 0x8000_0000, and `irq_o` is low.
- R2: A write to 0x40, 0x60, 0x48 or 0x68 ORs the write data into pending 0, pending 1, mask 0 or mask 1 respectively.
- R3: A write to 0x44, 0x64, 0x4C or 0x6C clears, in pending 0, pending 1, mask 0 or mask 1, exactly the bits written as one and leaves the others unchanged.
- R4: Bit 31 of pending 0 reads one exactly when pending 1 is nonzero. Bit 31 of data written to 0x40 or 0x44 has no effect on it.
- R5: Bit 31 of mask 0 reads one at all times after reset, including after a clear write that has bit 31 set.
- R6: `irq_o` is high exactly when the read value of pending 0 AND mask 0 is nonzero. Mask 1 does not gate it.
- R7: A low-to-high change on `src0_i[k]` (k in 0..30) or `src1_i[k]` (k in 0..31) sets pending bit k of bank 0 or bank 1 at the next clock edge. A source held high sets its bit only once.
- R8: When a source edge and a clear write to the same pending bit fall in the same cycle, the bit ends set. The other bits named in the clear write are still cleared.
- R9: A read of either the set address or the clear address of a register returns that register's current value.
- R10: An address outside the eight group addresses reads zero, and a write to it changes no register. The group is the set of addresses equal to 0x40 once bits 0x2C are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |
| src0_i | input | DATA_W-1 | Hardware sources for pending 0 bits 30..0 |
| src1_i | input | DATA_W | Hardware sources for pending 1 |
| irq_o | output | 1 | Interrupt request toward the processor |

## Verification
A hardware edge on a source and a bus clear write to the same pending register can land in the same clock edge. The bench provokes this by raising one source bit in the cycle that a clear write names both that bit and an already pending neighbour. It then reads the register back and expects the source bit set and the neighbour cleared. A long pseudo-random write sweep over all group addresses and a few outside ones is compared after every write against a register model kept in the bench. The chained bit 31 is walked through every bank-1 bit.

// File: rtl/casc_intc_pkg.sv
package casc_intc_pkg;

   // Register group location: the eight registers share one base once the
   // select bits are ignored.
   localparam int unsigned GRP_BASE  = 32'h0000_0040;
   localparam int unsigned GRP_SEL   = 32'h0000_002C;
   localparam int unsigned BANK_BIT  = 5;   // 0: bank 0, 1: bank 1
   localparam int unsigned MASK_BIT  = 3;   // 0: pending, 1: mask
   localparam int unsigned CLR_BIT   = 2;   // 0: set port, 1: clear port

   typedef struct packed {
      logic hit;
      logic bank;
      logic is_mask;
      logic is_clr;
   } grp_dec_t;

   typedef enum logic [1:0] {
      SEL_PEND0 = 2'b00,
      SEL_MASK0 = 2'b01,
      SEL_PEND1 = 2'b10,
      SEL_MASK1 = 2'b11
   } reg_sel_e;

endpackage

// File: rtl/casc_intc_decode.sv
module casc_intc_decode
   import casc_intc_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic [ADDR_W-1:0] addr_i,
   output grp_dec_t          dec_o
);

   localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(GRP_BASE);
   localparam logic [ADDR_W-1:0] SEL_A  = ADDR_W'(GRP_SEL);

   initial begin
      if (ADDR_W < 7) $error("casc_intc_decode: ADDR_W must be at least 7");
   end

   always_comb begin
      dec_o.hit     = ((addr_i & ~SEL_A) == BASE_A);
      dec_o.bank    = addr_i[BANK_BIT];
      dec_o.is_mask = addr_i[MASK_BIT];
      dec_o.is_clr  = addr_i[CLR_BIT];
   end

endmodule

// File: rtl/casc_intc_edge.sv
module casc_intc_edge #(
   parameter int W           = 32,
   parameter int SYNC_STAGES = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] src_i,
   output logic [W-1:0] rise_o
);

   logic [W-1:0] lvl;
   logic [W-1:0] prev_q;

   initial begin
      if (W < 1)           $error("casc_intc_edge: W must be positive");
      if (SYNC_STAGES < 0) $error("casc_intc_edge: SYNC_STAGES must be non-negative");
   end

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign lvl = src_i;
      end else begin : g_sync
         logic [W-1:0] sync_q [SYNC_STAGES];
         for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
               if (!rst_n)      sync_q[s] <= '0;
               else if (s == 0) sync_q[s] <= src_i;
               else             sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
            end
         end
         assign lvl = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl;
   end

   assign rise_o = lvl & ~prev_q;

   // R7: a level that stays high produces a single pulse
   a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));

endmodule

// File: rtl/casc_intc_w1sc.sv
module casc_intc_w1sc #(
   parameter int           W         = 32,
   parameter logic [W-1:0] RST_VAL   = '0,
   parameter logic [W-1:0] CLR_FORCE = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o
);

   logic [W-1:0] q_d;

   initial begin
      if (W < 1) $error("casc_intc_w1sc: W must be positive");
   end

   always_comb begin
      q_d = (q_o & ~clr_i) | set_i;
      if (clr_i != '0) q_d = q_d | CLR_FORCE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) q_o <= RST_VAL;
      else        q_o <= q_d;
   end

   // R2 / R8: a set request always lands, whatever clear arrives with it
   a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i)));

   // R3: bits cleared and not set or forced read zero afterwards
   a_r3_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_i & ~set_i & ~CLR_FORCE) != '0)
      |=> ((q_o & $past(clr_i & ~set_i & ~CLR_FORCE)) == '0));

   // R10: with no request the register holds
   a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i == '0 && clr_i == '0) |=> $stable(q_o));

endmodule

// File: rtl/casc_intc.sv
module casc_intc
   import casc_intc_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 12,
   parameter int SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_we,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [DATA_W-2:0] src0_i,
   input  logic [DATA_W-1:0] src1_i,
   output logic              irq_o
);

   localparam int           LOW_W    = DATA_W - 1;
   localparam logic [DATA_W-1:0] TOP_BIT = {1'b1, {LOW_W{1'b0}}};

   initial begin
      if (DATA_W < 2) $error("casc_intc: DATA_W must be at least 2");
      if (ADDR_W < 7) $error("casc_intc: ADDR_W must be at least 7");
   end

   grp_dec_t    dec;
   reg_sel_e    sel;
   logic        wr_hit;

   logic [LOW_W-1:0]  rise0;
   logic [DATA_W-1:0] rise1;

   logic [LOW_W-1:0]  p0_set, p0_clr, p0_q;
   logic [DATA_W-1:0] p1_set, p1_clr, p1_q;
   logic [DATA_W-1:0] m0_set, m0_clr, m0_q;
   logic [DATA_W-1:0] m1_set, m1_clr, m1_q;
   logic [DATA_W-1:0] p0_view;

   casc_intc_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr_i (bus_addr),
      .dec_o  (dec)
   );

   assign sel    = reg_sel_e'({dec.bank, dec.is_mask});
   assign wr_hit = bus_we & dec.hit;

   casc_intc_edge #(.W(LOW_W), .SYNC_STAGES(SYNC_STAGES)) u_edge0 (
      .clk    (clk),
      .rst_n  (rst_n),
      .src_i  (src0_i),
      .rise_o (rise0)
   );

   casc_intc_edge #(.W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_edge1 (
      .clk    (clk),
      .rst_n  (rst_n),
      .src_i  (src1_i),
      .rise_o (rise1)
   );

   // Write strobes per register: set port and clear port
   always_comb begin
      p0_set = rise0;
      p0_clr = '0;
      p1_set = rise1;
      p1_clr = '0;
      m0_set = '0;
      m0_clr = '0;
      m1_set = '0;
      m1_clr = '0;
      if (wr_hit) begin
         unique case (sel)
            SEL_PEND0: if (dec.is_clr) p0_clr = bus_wdata[LOW_W-1:0];
                       else            p0_set = p0_set | bus_wdata[LOW_W-1:0];
            SEL_MASK0: if (dec.is_clr) m0_clr = bus_wdata;
                       else            m0_set = bus_wdata;
            SEL_PEND1: if (dec.is_clr) p1_clr = bus_wdata;
                       else            p1_set = p1_set | bus_wdata;
            SEL_MASK1: if (dec.is_clr) m1_clr = bus_wdata;
                       else            m1_set = bus_wdata;
            default: ;
         endcase
      end
   end

   casc_intc_w1sc #(.W(LOW_W)) u_pend0 (
      .clk (clk), .rst_n (rst_n), .set_i (p0_set), .clr_i (p0_clr), .q_o (p0_q)
   );

   casc_intc_w1sc #(.W(DATA_W)) u_pend1 (
      .clk (clk), .rst_n (rst_n), .set_i (p1_set), .clr_i (p1_clr), .q_o (p1_q)
   );

   casc_intc_w1sc #(.W(DATA_W), .RST_VAL(TOP_BIT), .CLR_FORCE(TOP_BIT)) u_mask0 (
      .clk (clk), .rst_n (rst_n), .set_i (m0_set), .clr_i (m0_clr), .q_o (m0_q)
   );

   casc_intc_w1sc #(.W(DATA_W)) u_mask1 (
      .clk (clk), .rst_n (rst_n), .set_i (m1_set), .clr_i (m1_clr), .q_o (m1_q)
   );

   // Cascade: bank 1 summary sits in the top bit of pending 0
   assign p0_view = {|p1_q, p0_q};
   assign irq_o   = |(p0_view & m0_q);

   always_comb begin
      bus_rdata = '0;
      if (dec.hit) begin
         unique case (sel)
            SEL_PEND0: bus_rdata = p0_view;
            SEL_MASK0: bus_rdata = m0_q;
            SEL_PEND1: bus_rdata = p1_q;
            SEL_MASK1: bus_rdata = m1_q;
            default:   bus_rdata = '0;
         endcase
      end
   end

   // R5: the cascade enable never drops
   a_r5_cascade_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      m0_q[DATA_W-1]);

   // R4 / R6: anything pending in bank 1 reaches the interrupt line
   a_r6_bank1_reaches_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (p1_q != '0) |-> irq_o);

   // R10: a write outside the group leaves every register as it was
   a_r10_miss_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && !dec.hit && rise0 == '0 && rise1 == '0)
      |=> ($stable(p0_q) && $stable(p1_q) && $stable(m0_q) && $stable(m1_q)));

endmodule

// File: tb/casc_intc_bench.sv
`timescale 1ns/100ps
module casc_intc_bench;

   localparam int DW = 32;
   localparam int AW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic          bus_we = 1'b0;
   logic [DW-1:0] bus_rdata;
   logic [DW-2:0] src0 = '0;
   logic [DW-1:0] src1 = '0;
   logic          irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // bench model
   logic [DW-1:0] e_p0, e_p1, e_m0, e_m1;

   casc_intc #(.DATA_W(DW), .ADDR_W(AW)) u_casc_intc (
      .clk (clk), .rst_n (rst_n),
      .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_we (bus_we),
      .bus_rdata (bus_rdata),
      .src0_i (src0), .src1_i (src1), .irq_o (irq)
   );

   always #2.5 clk = ~clk;

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] view_p0();
      return {(e_p1 != 0), e_p0[DW-2:0]};
   endfunction

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      bus_addr = a;
      #0.5;
      d = bus_rdata;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   function automatic void model_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      if ((a & ~12'h02C) == 12'h040) begin
         case ({a[5], a[3], a[2]})
            3'b000: e_p0 = e_p0 | (d & 32'h7FFF_FFFF);
            3'b001: e_p0 = e_p0 & ~d;
            3'b010: e_m0 = e_m0 | d;
            3'b011: e_m0 = (e_m0 & ~d) | ((d != 0) ? 32'h8000_0000 : 32'h0);
            3'b100: e_p1 = e_p1 | d;
            3'b101: e_p1 = e_p1 & ~d;
            3'b110: e_m1 = e_m1 | d;
            default: e_m1 = e_m1 & ~d;
         endcase
         e_p0[DW-1] = 1'b0;
      end
   endfunction

   task automatic check_all(input string req);
      logic [DW-1:0] d;
      rd(12'h040, d); chk({req, " pend0"}, d, view_p0());
      rd(12'h048, d); chk({req, " mask0"}, d, e_m0);
      rd(12'h060, d); chk({req, " pend1"}, d, e_p1);
      rd(12'h068, d); chk({req, " mask1"}, d, e_m1);
      chk({req, " irq"}, {31'd0, irq}, {31'd0, ((view_p0() & e_m0) != 0)});
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin : stim
      logic [DW-1:0] d;
      logic [31:0]   lf;
      logic [AW-1:0] a;
      logic [AW-1:0] addrs [12];
      addrs = '{12'h040, 12'h044, 12'h048, 12'h04C, 12'h060, 12'h064,
                12'h068, 12'h06C, 12'h050, 12'h020, 12'h140, 12'h0C0};
      e_p0 = 0; e_p1 = 0; e_m0 = 32'h8000_0000; e_m1 = 0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check_all("R1");

      // R2 / R3 directed
      wr(12'h040, 32'h0000_00F0); model_wr(12'h040, 32'h0000_00F0);
      check_all("R2");
      wr(12'h048, 32'h0000_0030); model_wr(12'h048, 32'h0000_0030);
      check_all("R6");
      wr(12'h044, 32'h0000_0050); model_wr(12'h044, 32'h0000_0050);
      check_all("R3");

      // R9: clear address reads the same register
      rd(12'h044, d); chk("R9 pend0 via clr", d, view_p0());
      rd(12'h04C, d); chk("R9 mask0 via clr", d, e_m0);
      rd(12'h064, d); chk("R9 pend1 via clr", d, e_p1);
      rd(12'h06C, d); chk("R9 mask1 via clr", d, e_m1);

      // R5: clear write naming bit 31 of mask0
      wr(12'h04C, 32'hFFFF_FFFF); model_wr(12'h04C, 32'hFFFF_FFFF);
      rd(12'h048, d); chk("R5 mask0 after full clear", d, 32'h8000_0000);

      // R4: bit 31 of pending 0 is not writable
      wr(12'h040, 32'h8000_0000); model_wr(12'h040, 32'h8000_0000);
      rd(12'h040, d); chk("R4 bit31 write ignored", d, view_p0());

      // R4 / R6: walk the cascade through every bank-1 bit
      wr(12'h044, 32'hFFFF_FFFF); model_wr(12'h044, 32'hFFFF_FFFF);
      for (int i = 0; i < DW; i++) begin
         wr(12'h060, 32'h1 << i); model_wr(12'h060, 32'h1 << i);
         rd(12'h040, d); chk("R4 cascade set", d, 32'h8000_0000);
         chk("R6 cascade irq", {31'd0, irq}, 32'd1);
         wr(12'h064, 32'h1 << i); model_wr(12'h064, 32'h1 << i);
         rd(12'h040, d); chk("R4 cascade clear", d, 32'h0);
         chk("R6 irq idle", {31'd0, irq}, 32'd0);
      end

      // R7: source edges, one bit at a time, both banks
      for (int i = 0; i < DW; i++) begin
         @(negedge clk);
         if (i < DW-1) src0[i] = 1'b1;
         src1[i] = 1'b1;
         @(negedge clk);
         src0 = '0; src1 = '0;
         if (i < DW-1) e_p0[i] = 1'b1;
         e_p1[i] = 1'b1;
         check_all("R7 edge");
         wr(12'h044, 32'hFFFF_FFFF); model_wr(12'h044, 32'hFFFF_FFFF);
         wr(12'h064, 32'hFFFF_FFFF); model_wr(12'h064, 32'hFFFF_FFFF);
      end

      // R7: held level sets only once
      @(negedge clk); src0[5] = 1'b1;
      @(negedge clk); e_p0[5] = 1'b1;
      wr(12'h044, 32'h0000_0020); model_wr(12'h044, 32'h0000_0020);
      repeat (3) @(negedge clk);
      rd(12'h040, d); chk("R7 held level no retrigger", d, view_p0());
      src0 = '0;

      // R8: edge on bit 3 and clear of bits 3,4 in the same cycle
      wr(12'h040, 32'h0000_0010); model_wr(12'h040, 32'h0000_0010);
      @(negedge clk);
      bus_addr = 12'h044; bus_wdata = 32'h0000_0018; bus_we = 1'b1;
      src0[3] = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; src0 = '0;
      model_wr(12'h044, 32'h0000_0018); e_p0[3] = 1'b1;
      rd(12'h040, d); chk("R8 edge beats clear", d & 32'h18, 32'h08);
      // R8 on bank 1 likewise
      wr(12'h060, 32'h0000_0001); model_wr(12'h060, 32'h0000_0001);
      @(negedge clk);
      bus_addr = 12'h064; bus_wdata = 32'h8000_0001; bus_we = 1'b1;
      src1[31] = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; src1 = '0;
      model_wr(12'h064, 32'h8000_0001); e_p1[31] = 1'b1;
      check_all("R8 bank1");

      // R10: outside addresses read zero
      rd(12'h050, d); chk("R10 read miss 0x050", d, 32'h0);
      rd(12'h140, d); chk("R10 read miss 0x140", d, 32'h0);

      // R2 / R3 / R9 / R10: pseudo-random sweep against the model
      lf = 32'hACE1_2357;
      for (int n = 0; n < 600; n++) begin
         lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
         a = addrs[lf[3:0] % 12];
         d = lf;
         lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
         d = d & lf;
         wr(a, d); model_wr(a, d);
         check_all("R2 R3 R10 sweep");
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule